// File: doc/BRIEF.md
# Decimal On-the-Fly Quotient Converter with Guard-Digit Rounding

This block sits behind a radix-10 digit-recurrence divider whose quotient digits are signed values in the minimally redundant set from -5 to +5. It takes one such digit per beat and assembles the plain BCD quotient while the digits stream in. It needs no carry-propagating addition during accumulation. Two registers are kept side by side: the running quotient and the same value minus one. Each new digit therefore only shifts one of them left by a decimal position and appends a new low digit.

After the kept digits, one more digit arrives. It is a guard digit used only for rounding. On that beat the sign of the divider's final remainder is captured. When the remainder is negative, the decremented register becomes the result, so the correction costs no arithmetic. In automatic mode the guard digit is dropped. Because the digit set is symmetric about zero, the truncation error is already balanced. In ties-to-even mode, one BCD increment may be applied in a single extra cycle. The kept stream is read as an integer with the first digit most significant. The divider's two-place prescale of the dividend is thus undone by position alone, with no shift step.

Top module: `dec_otf_quotient`

## Requirements
- R1: A high `start` clears `done` on the next cycle and restarts accumulation from a running value of 0 with its companion at 10^NDIG-1; the rounding mode is latched from `rnd_even` on that beat; `start` takes priority over every other input.
- R2: `digit` is 4-bit two's complement and must lie in -5..+5 on every beat where `digit_valid` is high.
- R3: After NDIG accepted digits d1..dNDIG (d1 first), the running value equals the sum of d_i*10^(NDIG-i) taken modulo 10^NDIG, and digits may be negative at any position.
- R4: The companion register always equals the running value minus one modulo 10^NDIG.
- R5: The beat after the NDIG kept digits carries the guard digit; `rem_neg` is sampled on that same beat, and when it is 1 the base result is the running value minus one modulo 10^NDIG, otherwise the running value itself.
- R6: With `rnd_even`=0 at start (automatic mode), `quotient` equals the base result for every guard value, including +5 and -5.
- R7: With `rnd_even`=1 at start, `quotient` is the base result plus one modulo 10^NDIG exactly when the guard digit is +5 and the base result is odd; otherwise it is the base result, so a guard of -5 causes no change.
- R8: `done` rises one clock after the guard beat; `done` and `quotient` then hold until the next `start`; `quotient` is NDIG BCD digits, least significant digit in bits 3:0.
- R9: `digit_valid` beats outside an accumulation are ignored. This covers the time before the first start, beats after the guard digit, and beats while `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new quotient |
| rnd_even | input | 1 | Rounding mode at start: 0 automatic, 1 ties-to-even |
| digit_valid | input | 1 | A quotient digit is present |
| digit | input | 4 | Signed quotient digit, two's complement, -5..+5 |
| rem_neg | input | 1 | Final remainder sign, sampled with the guard digit |
| quotient | output | 4*NDIG | BCD quotient, digit 0 in bits 3:0 |
| done | output | 1 | Quotient valid, held until next start |

## Verification
Directed streams are used for specific paths. An all-zero stream with a negative remainder exercises the full borrow across every digit position, which turns zero into all nines. That case is then rounded in ties-to-even mode, so the increment wraps back to zero. Streams led by a one and followed by negative digits drive the path that appends from the decremented register at every position. Guard values of +5 and -5 are applied against odd and even kept digits in both modes. This separates automatic truncation from ties-to-even rounding and shows that -5 never rounds. Random streams mixed with stray valid beats while idle compare the converter with an exact integer sum of the digits on every clock. This confirms the ignored beats leave the held result alone.

// File: rtl/qcv_pkg.sv
package qcv_pkg;
  localparam int DIGW = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_FIN  = 2'd2
  } qcv_state_e;

  // low digit appended to the running value (q >= 0: q, q < 0: 10+q)
  function automatic logic [3:0] q_low(input logic [3:0] d);
    q_low = d[3] ? (d + 4'd10) : d;
  endfunction

  // low digit appended to the decremented value (q > 0: q-1, q <= 0: 9+q)
  function automatic logic [3:0] qm_low(input logic [3:0] d);
    qm_low = (!d[3] && d != 4'd0) ? (d - 4'd1) : (d + 4'd9);
  endfunction
endpackage

// File: rtl/qcv_append.sv
module qcv_append
  import qcv_pkg::*;
#(
  parameter int NDIG = 16
) (
  input  logic [4*NDIG-1:0] q_cur,
  input  logic [4*NDIG-1:0] qm_cur,
  input  logic [3:0]        digit,
  output logic [4*NDIG-1:0] q_nxt,
  output logic [4*NDIG-1:0] qm_nxt
);
  localparam int W = 4 * NDIG;

  logic neg, pos;
  logic [W-1:0] src_q, src_qm;

  always_comb begin
    neg    = digit[3];
    pos    = !digit[3] && (digit != 4'd0);
    src_q  = neg ? qm_cur : q_cur;
    src_qm = pos ? q_cur : qm_cur;
    q_nxt  = {src_q[W-5:0], q_low(digit)};
    qm_nxt = {src_qm[W-5:0], qm_low(digit)};
  end
endmodule

// File: rtl/qcv_bcd_inc.sv
module qcv_bcd_inc #(
  parameter int NDIG = 16
) (
  input  logic [4*NDIG-1:0] val,
  output logic [4*NDIG-1:0] val_inc
);
  logic [NDIG:0] cy;
  assign cy[0] = 1'b1;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    logic [3:0] dg;
    assign dg = val[4*g +: 4];
    assign cy[g+1] = cy[g] && (dg == 4'd9);
    assign val_inc[4*g +: 4] = !cy[g] ? dg : ((dg == 4'd9) ? 4'd0 : dg + 4'd1);
  end
endmodule

// File: rtl/qcv_final.sv
module qcv_final #(
  parameter int NDIG = 16
) (
  input  logic [4*NDIG-1:0] q_val,
  input  logic [4*NDIG-1:0] qm_val,
  input  logic              neg,
  input  logic [3:0]        guard,
  input  logic              even_mode,
  output logic [4*NDIG-1:0] result
);
  logic [4*NDIG-1:0] base, base_up;
  logic              bump;

  assign base = neg ? qm_val : q_val;

  qcv_bcd_inc #(.NDIG(NDIG)) u_inc (
    .val     (base),
    .val_inc (base_up)
  );

  assign bump   = even_mode && (guard == 4'd5) && base[0];
  assign result = bump ? base_up : base;
endmodule

// File: rtl/dec_otf_quotient.sv
module dec_otf_quotient
  import qcv_pkg::*;
#(
  parameter int NDIG = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rnd_even,
  input  logic              digit_valid,
  input  logic [3:0]        digit,
  input  logic              rem_neg,
  output logic [4*NDIG-1:0] quotient,
  output logic              done
);
  localparam int W  = 4 * NDIG;
  localparam int CW = $clog2(NDIG + 1);
  localparam logic [W-1:0]  NINES = {NDIG{4'h9}};
  localparam logic [CW-1:0] LAST  = CW'(NDIG);

  qcv_state_e    state;
  logic [W-1:0]  q_r, qm_r, q_nxt, qm_nxt, res;
  logic [CW-1:0] cnt;
  logic [3:0]    guard_r;
  logic          neg_r, mode_r;
  logic [W-1:0]  quot_r;
  logic          done_r;

  qcv_append #(.NDIG(NDIG)) u_app (
    .q_cur  (q_r),
    .qm_cur (qm_r),
    .digit  (digit),
    .q_nxt  (q_nxt),
    .qm_nxt (qm_nxt)
  );

  qcv_final #(.NDIG(NDIG)) u_fin (
    .q_val     (q_r),
    .qm_val    (qm_r),
    .neg       (neg_r),
    .guard     (guard_r),
    .even_mode (mode_r),
    .result    (res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      q_r     <= '0;
      qm_r    <= NINES;
      cnt     <= '0;
      guard_r <= '0;
      neg_r   <= 1'b0;
      mode_r  <= 1'b0;
      quot_r  <= '0;
      done_r  <= 1'b0;
    end else if (start) begin
      state  <= ST_ACC;
      q_r    <= '0;
      qm_r   <= NINES;
      cnt    <= '0;
      mode_r <= rnd_even;
      done_r <= 1'b0;
    end else begin
      unique case (state)
        ST_ACC: begin
          if (digit_valid) begin
            if (cnt == LAST) begin
              guard_r <= digit;
              neg_r   <= rem_neg;
              state   <= ST_FIN;
            end else begin
              q_r  <= q_nxt;
              qm_r <= qm_nxt;
              cnt  <= cnt + 1'b1;
            end
          end
        end
        ST_FIN: begin
          quot_r <= res;
          done_r <= 1'b1;
          state  <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign quotient = quot_r;
  assign done     = done_r;
endmodule

// File: rtl/qcv_checker.sv
module qcv_checker #(
  parameter int NDIG = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              digit_valid,
  input logic [3:0]        digit,
  input logic [4*NDIG-1:0] quotient,
  input logic              done,
  input logic [4*NDIG-1:0] q_r,
  input logic [4*NDIG-1:0] qm_r,
  input logic              neg_r,
  input logic              mode_r
);
  p_start_clears_r1: assert property (@(posedge clk) disable iff (rst)
    start |=> !done);

  p_digit_range_r2: assert property (@(posedge clk) disable iff (rst)
    digit_valid |-> ($signed(digit) >= -4'sd5 && $signed(digit) <= 4'sd5));

  p_pair_low_r4: assert property (@(posedge clk) disable iff (rst)
    qm_r[3:0] == ((q_r[3:0] == 4'd0) ? 4'd9 : q_r[3:0] - 4'd1));

  p_auto_keeps_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(done) && !mode_r) |-> quotient == (neg_r ? qm_r : q_r));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(quotient)));
endmodule

bind dec_otf_quotient qcv_checker #(.NDIG(NDIG)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .digit_valid (digit_valid),
  .digit       (digit),
  .quotient    (quotient),
  .done        (done),
  .q_r         (q_r),
  .qm_r        (qm_r),
  .neg_r       (neg_r),
  .mode_r      (mode_r)
);

// File: tb/sim_dec_otf_quotient.sv
module sim_dec_otf_quotient;
  localparam int NDIG = 16;
  localparam longint MODV = 64'd10_000_000_000_000_000;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, rnd_even = 1'b0;
  logic digit_valid = 1'b0, rem_neg = 1'b0;
  logic [3:0] digit = 4'd0;
  logic [4*NDIG-1:0] quotient;
  logic done;

  int vectors = 0, errors = 0, cycles = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  dec_otf_quotient #(.NDIG(NDIG)) u0 (
    .clk(clk), .rst(rst), .start(start), .rnd_even(rnd_even),
    .digit_valid(digit_valid), .digit(digit), .rem_neg(rem_neg),
    .quotient(quotient), .done(done)
  );

  // behavioural reference model
  longint acc = 0, exp_q = 0;
  int cnt = 0, gd = 0;
  bit busy = 0, fin = 0, mode = 0, neg = 0, exp_done = 0;

  function automatic longint md(input longint x);
    longint r;
    r = x % MODV;
    if (r < 0) r += MODV;
    return r;
  endfunction

  function automatic longint bcd2int(input logic [4*NDIG-1:0] v);
    longint r = 0;
    for (int i = NDIG - 1; i >= 0; i--) r = r * 10 + longint'(v[4*i +: 4]);
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      busy = 0; fin = 0; exp_done = 0; exp_q = 0;
    end else if (start) begin
      acc = 0; cnt = 0; busy = 1; fin = 0; exp_done = 0; mode = rnd_even;
    end else if (fin) begin
      longint base;
      base = neg ? md(acc - 1) : acc;
      if (mode && gd == 5 && (base % 2) == 1) base = md(base + 1);
      exp_q = base; exp_done = 1; fin = 0;
    end else if (busy && digit_valid) begin
      if (cnt < NDIG) begin
        acc = md(acc * 10 + longint'($signed(digit)));
        cnt++;
      end else begin
        gd = int'($signed(digit)); neg = rem_neg; busy = 0; fin = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      vectors++;
      if (done !== exp_done) begin
        errors++;
        $display("FAIL %s done actual=%0b expected=%0b", tag, done, exp_done);
      end
      vectors++;
      if (bcd2int(quotient) != exp_q) begin
        errors++;
        $display("FAIL %s quotient actual=%h expected=%0d", tag, quotient, exp_q);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  int dq[$];

  task automatic beat(input int d, input bit v);
    digit_valid = v; digit = 4'(d);
    @(negedge clk);
    digit_valid = 1'b0; digit = 4'd0;
  endtask

  task automatic run(input bit even, input int guard, input bit rneg, input int gap);
    start = 1'b1; rnd_even = even;
    @(negedge clk);
    start = 1'b0; rnd_even = 1'b0;
    foreach (dq[i]) begin
      beat(dq[i], 1'b1);
      for (int k = 0; k < gap; k++) beat(0, 1'b0);
    end
    rem_neg = rneg;
    beat(guard, 1'b1);
    rem_neg = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic fill_const(input int first, input int rest);
    dq.delete();
    dq.push_back(first);
    for (int i = 1; i < NDIG; i++) dq.push_back(rest);
  endtask

  task automatic fill_rand();
    dq.delete();
    dq.push_back($urandom_range(0, 1));
    for (int i = 1; i < NDIG; i++) dq.push_back(int'($urandom_range(0, 10)) - 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tag = "R9";                       // stray beats before any start
    beat(3, 1'b1); beat(-2, 1'b1);
    @(negedge clk);

    tag = "R3"; fill_const(0, 0);  run(0, 0, 0, 0);   // all zeros
    tag = "R4"; fill_const(0, 0);  run(0, 0, 1, 0);   // 0-1 -> all nines
    tag = "R7"; fill_const(0, 0);  run(1, 5, 1, 0);   // nines odd +5 wraps to 0
    tag = "R3"; fill_const(1, -1); run(0, 2, 0, 1);   // negatives, gaps
    tag = "R5"; fill_const(1, -1); run(0, -3, 1, 0);
    tag = "R6"; fill_const(0, 3);  run(0, 5, 0, 0);   // odd, +5, auto: no change
    tag = "R6"; fill_const(0, 3);  run(0, -5, 0, 0);
    tag = "R7"; fill_const(0, 3);  run(1, 5, 0, 0);   // odd, +5 -> up
    tag = "R7"; fill_const(0, 2);  run(1, 5, 0, 0);   // even, +5 -> hold
    tag = "R7"; fill_const(0, 3);  run(1, -5, 0, 0);  // -5 never rounds
    tag = "R7"; fill_const(0, 2);  run(1, 5, 1, 0);   // even-1 odd -> up

    tag = "R9";                       // beats while done high are ignored
    beat(4, 1'b1); beat(-5, 1'b1); beat(1, 1'b1);
    @(negedge clk);

    tag = "R1";                       // start mid-stream restarts cleanly
    start = 1'b1; @(negedge clk); start = 1'b0;
    beat(5, 1'b1); beat(5, 1'b1);
    fill_const(1, 4); run(0, 1, 0, 0);

    tag = "R8";
    for (int n = 0; n < 300; n++) begin
      fill_rand();
      run($urandom_range(0, 1), int'($urandom_range(0, 10)) - 5,
          $urandom_range(0, 1), $urandom_range(0, 1));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule